// File: doc/BRIEF.md
# Ethernet PHY Status LED Driver

This block turns the live state of a 10/100 Ethernet transceiver into four status-LED levels: activity, link, speed-100 and full-duplex. It watches carrier sense, the two per-speed link-valid flags, the resolved speed, an auto-negotiation-busy flag, a line-isolate control bit and the duplex mode. Every output is registered, so each one is updated one clock after the inputs it depends on.

A 4-bit strap value is sampled while reset is held. Each strap bit sets the electrical polarity of one LED, so the same block can drive LEDs wired to the supply or to ground. After the carrier goes away, the activity LED stays lit for a fixed hold time, 128 ms by default. That time is counted in millisecond ticks taken from a prescaler, which is set by the clock frequency parameter.

Top module: `phy_led_driver`

## Requirements
- R1: Strap bit 0 sets the polarity of the activity LED, bit 1 the link LED, bit 2 the speed LED and bit 3 the duplex LED. A bit of 1 makes that LED active-low and a bit of 0 makes it active-high. The value kept is the one sampled on the last rising edge with `rst_n` low.
- R2: Once reset is released, changes on `strap_i` have no effect on any output until the next reset.
- R3: On every edge with `rst_n` low, each LED output is driven to its inactive level, which equals its strap bit sampled on that edge.
- R4: The activity LED is active in the cycle after any edge that samples `crs_i` high.
- R5: After the last edge that samples `crs_i` high, the activity LED stays active for HOLD_MS × (CLK_FREQ_HZ/1000) more edges and goes inactive on the edge that follows them.
- R6: If carrier sense is sampled high again during the hold time, the hold time restarts in full, so the LED never drops between bursts.
- R7: The link LED is active when the link flag for the resolved speed is set. That flag is `link_ok100_i` when `speed100_i` is 1, and `link_ok10_i` otherwise.
- R8: The speed LED is active when `speed100_i` or `aneg_busy_i` is 1, unless `isolate_i` is 1, which forces it inactive.
- R9: The duplex LED is active when `full_duplex_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_i | input | 4 | Polarity straps: [0] activity, [1] link, [2] speed, [3] duplex |
| crs_i | input | 1 | Carrier sense |
| link_ok10_i | input | 1 | Valid link at 10 Mb/s |
| link_ok100_i | input | 1 | Valid link at 100 Mb/s |
| speed100_i | input | 1 | Resolved speed is 100 Mb/s |
| aneg_busy_i | input | 1 | Auto-negotiation in progress |
| isolate_i | input | 1 | Line isolate control bit |
| full_duplex_i | input | 1 | Link is in full-duplex mode |
| led_act_o | output | 1 | Activity LED level |
| led_link_o | output | 1 | Link LED level |
| led_spd_o | output | 1 | Speed-100 LED level |
| led_fdx_o | output | 1 | Full-duplex LED level |

## Verification
Link, speed, duplex and the rising edge of activity all pass through a single output register. The bench therefore drives each stimulus on a falling edge and checks the result on the next falling edge, exactly one rising edge later. The end of the activity hold is counted from the last edge that sampled carrier high. The bench checks that the LED is still lit after HOLD_MS × ticks-per-ms edges and that it is dark one edge later, which pins the hold to the exact cycle. Reset-level and strap checks are made after the last reset edge and after the first edge following release.

// File: rtl/phy_led_pkg.sv
`timescale 1ns/1ps
// Package: phy_led_pkg
// Shared LED vector type and bit positions for the status LED driver.
// Assumes four LEDs; the positions match the strap bit mapping.
package phy_led_pkg;
    localparam int LED_N    = 4;
    localparam int IDX_ACT  = 0;
    localparam int IDX_LINK = 1;
    localparam int IDX_SPD  = 2;
    localparam int IDX_FDX  = 3;

    typedef logic [LED_N-1:0] led_vec_t;

    // Turn "LED on" bits into pin levels: a polarity bit of 1 inverts (active-low).
    function automatic led_vec_t to_level(led_vec_t on_bits, led_vec_t pol);
        return on_bits ^ pol;
    endfunction
endpackage

// File: rtl/led_strap_latch.sv
`timescale 1ns/1ps
// Module: led_strap_latch
// Follows the strap inputs on every edge while reset is low and freezes
// the last sampled value once reset is released.
// Assumes straps are stable near the last reset edge.
module led_strap_latch
    import phy_led_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  led_vec_t strap_i,
    output led_vec_t pol_o
);
    led_vec_t pol_q;

    // Track straps during reset, hold afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q <= strap_i;
        end
    end

    assign pol_o = pol_q;

    AST_POL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(pol_q)); // R2
endmodule

// File: rtl/led_hold_timer.sv
`timescale 1ns/1ps
// Module: led_hold_timer
// Retriggerable hold timer. Carrier sense loads HOLD_TICKS. Once carrier
// drops, a prescaler produces one tick every TICK_DIV clocks and each tick
// decrements the count. busy_o is high while the count is non-zero.
// Assumes TICK_DIV >= 1 and HOLD_TICKS >= 1.
module led_hold_timer #(
    parameter int TICK_DIV   = 50000,
    parameter int HOLD_TICKS = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic crs_i,
    output logic busy_o
);
    localparam int HW = $clog2(HOLD_TICKS + 1);

    logic [HW-1:0] hold_q;
    logic          tick;

    generate
        if (TICK_DIV > 1) begin : g_pre
            localparam int PRE_W = $clog2(TICK_DIV);
            logic [PRE_W-1:0] pre_q;

            // Prescaler: restarts while carrier is present, runs during the hold.
            always_ff @(posedge clk) begin
                if (!rst_n || crs_i) begin
                    pre_q <= '0;
                end else if (hold_q != '0) begin
                    pre_q <= (pre_q == PRE_W'(TICK_DIV - 1)) ? '0 : pre_q + 1'b1;
                end
            end

            assign tick = (pre_q == PRE_W'(TICK_DIV - 1));

            AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
                32'(pre_q) < TICK_DIV); // R5
        end else begin : g_nopre
            assign tick = 1'b1;
        end
    endgenerate

    // Hold counter: reload on carrier, count down on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (crs_i) begin
            hold_q <= HW'(HOLD_TICKS);
        end else if (hold_q != '0 && tick) begin
            hold_q <= hold_q - 1'b1;
        end
    end

    assign busy_o = (hold_q != '0);

    AST_HOLD_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        crs_i |=> hold_q == HW'(HOLD_TICKS)); // R6
    AST_HOLD_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !crs_i |=> hold_q <= $past(hold_q)); // R5
endmodule

// File: rtl/led_status_decode.sv
`timescale 1ns/1ps
// Module: led_status_decode
// Combinational decode of PHY status into "LED on" bits, before polarity.
// Assumes all inputs are synchronous to the block clock.
module led_status_decode
    import phy_led_pkg::*;
(
    input  logic     crs_i,
    input  logic     hold_busy_i,
    input  logic     link_ok10_i,
    input  logic     link_ok100_i,
    input  logic     speed100_i,
    input  logic     aneg_busy_i,
    input  logic     isolate_i,
    input  logic     full_duplex_i,
    output led_vec_t on_o
);
    // Build each LED's on condition.
    always_comb begin
        on_o           = '0;
        on_o[IDX_ACT]  = crs_i | hold_busy_i;
        on_o[IDX_LINK] = speed100_i ? link_ok100_i : link_ok10_i;
        on_o[IDX_SPD]  = !isolate_i && (speed100_i || aneg_busy_i);
        on_o[IDX_FDX]  = full_duplex_i;
    end
endmodule

// File: rtl/phy_led_driver.sv
`timescale 1ns/1ps
// Module: phy_led_driver
// Top of the status LED driver. It captures the polarity straps during reset,
// stretches activity with a millisecond-based hold timer, decodes the PHY
// status and registers the four LED levels.
// Assumes CLK_FREQ_HZ is a multiple of 1 kHz. Lower rates give one tick per clock.
module phy_led_driver #(
    parameter int CLK_FREQ_HZ = 50_000_000,
    parameter int HOLD_MS     = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] strap_i,
    input  logic       crs_i,
    input  logic       link_ok10_i,
    input  logic       link_ok100_i,
    input  logic       speed100_i,
    input  logic       aneg_busy_i,
    input  logic       isolate_i,
    input  logic       full_duplex_i,
    output logic       led_act_o,
    output logic       led_link_o,
    output logic       led_spd_o,
    output logic       led_fdx_o
);
    import phy_led_pkg::*;

    localparam int TICKS_PER_MS = CLK_FREQ_HZ / 1000;
    localparam int TICK_DIV     = (TICKS_PER_MS > 0) ? TICKS_PER_MS : 1;

    led_vec_t pol;
    led_vec_t on_bits;
    led_vec_t led_q;
    logic     hold_busy;

    led_strap_latch u_strap (
        .clk     (clk),
        .rst_n   (rst_n),
        .strap_i (strap_i),
        .pol_o   (pol)
    );

    led_hold_timer #(
        .TICK_DIV   (TICK_DIV),
        .HOLD_TICKS (HOLD_MS)
    ) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .crs_i  (crs_i),
        .busy_o (hold_busy)
    );

    led_status_decode u_dec (
        .crs_i         (crs_i),
        .hold_busy_i   (hold_busy),
        .link_ok10_i   (link_ok10_i),
        .link_ok100_i  (link_ok100_i),
        .speed100_i    (speed100_i),
        .aneg_busy_i   (aneg_busy_i),
        .isolate_i     (isolate_i),
        .full_duplex_i (full_duplex_i),
        .on_o          (on_bits)
    );

    // Output register: inactive levels in reset, polarity-applied status after.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led_q <= strap_i;
        end else begin
            led_q <= to_level(on_bits, pol);
        end
    end

    assign led_act_o  = led_q[IDX_ACT];
    assign led_link_o = led_q[IDX_LINK];
    assign led_spd_o  = led_q[IDX_SPD];
    assign led_fdx_o  = led_q[IDX_FDX];

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> {led_fdx_o, led_spd_o, led_link_o, led_act_o} == $past(strap_i)); // R3
    AST_ACT_ON: assert property (@(posedge clk) disable iff (!rst_n)
        crs_i |=> led_act_o != pol[IDX_ACT]); // R4
    AST_ISO_SPD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        isolate_i |=> led_spd_o == pol[IDX_SPD]); // R8
    AST_FDX_ON: assert property (@(posedge clk) disable iff (!rst_n)
        full_duplex_i |=> led_fdx_o != pol[IDX_FDX]); // R9
endmodule

// File: tb/phy_led_driver_tb.sv
`timescale 1ns/1ps
// Directed bench for phy_led_driver: one task per scenario.
module phy_led_driver_tb;
    localparam int CLK_HZ = 4000;
    localparam int HOLD   = 5;
    localparam int HD     = HOLD * (CLK_HZ / 1000);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] strap = 4'b0000;
    logic       crs = 1'b0, l10 = 1'b0, l100 = 1'b0, s100 = 1'b0;
    logic       aneg = 1'b0, iso = 1'b0, fdx = 1'b0;
    logic       led_act, led_link, led_spd, led_fdx;
    logic [3:0] pol = 4'b0000;
    int         checks = 0;
    int         fails = 0;
    bit         done = 1'b0;

    wire [3:0] leds = {led_fdx, led_spd, led_link, led_act};

    always #10 clk = ~clk;

    phy_led_driver #(.CLK_FREQ_HZ(CLK_HZ), .HOLD_MS(HOLD)) u_dut (
        .clk(clk), .rst_n(rst_n), .strap_i(strap), .crs_i(crs),
        .link_ok10_i(l10), .link_ok100_i(l100), .speed100_i(s100),
        .aneg_busy_i(aneg), .isolate_i(iso), .full_duplex_i(fdx),
        .led_act_o(led_act), .led_link_o(led_link), .led_spd_o(led_spd),
        .led_fdx_o(led_fdx)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [3:0] got, logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: leds got %b expected %b", req, got, exp);
        end
    endtask

    // Expected levels for given on-bits {fdx,spd,link,act} under current polarity.
    task automatic chk_on(string req, logic [3:0] on_bits);
        chk(req, leds, on_bits ^ pol);
    endtask

    task automatic clear_inputs();
        crs = 0; l10 = 0; l100 = 0; s100 = 0; aneg = 0; iso = 0; fdx = 0;
    endtask

    // R1/R3: reset levels follow the straps, the last reset edge decides polarity.
    task automatic do_reset(logic [3:0] early, logic [3:0] last);
        @(negedge clk);
        rst_n = 0; strap = early; clear_inputs();
        repeat (3) step();
        chk("R3 reset level early", leds, early);
        strap = last;
        step();
        chk("R3 reset level last edge", leds, last);
        rst_n = 1; strap = ~last; pol = last;
        step();
        chk_on("R1 idle after release uses last strap", 4'b0000);
    endtask

    // R7: link flag chosen by resolved speed; R8 speed LED follows too.
    task automatic test_link();
        l10 = 1; s100 = 0; step();
        chk_on("R7 link at 10", 4'b0010);
        s100 = 1; l100 = 0; step();
        chk_on("R7 100 selected, flag low", 4'b0100);
        l100 = 1; step();
        chk_on("R7 link at 100", 4'b0110);
        l10 = 0; step();
        chk_on("R7 10 flag ignored at 100", 4'b0110);
        clear_inputs(); step();
    endtask

    // R8: auto-negotiation forces on, isolate forces off.
    task automatic test_speed();
        aneg = 1; step();
        chk_on("R8 on during autoneg", 4'b0100);
        iso = 1; step();
        chk_on("R8 off when isolated (autoneg)", 4'b0000);
        aneg = 0; s100 = 1; step();
        chk_on("R8 off when isolated (100)", 4'b0000);
        iso = 0; step();
        chk_on("R8 on at 100", 4'b0100);
        clear_inputs(); step();
        chk_on("R8 off at 10", 4'b0000);
    endtask

    // R9: duplex LED.
    task automatic test_duplex();
        fdx = 1; step();
        chk_on("R9 full duplex on", 4'b1000);
        fdx = 0; step();
        chk_on("R9 half duplex off", 4'b0000);
    endtask

    // R4/R5: activity on next cycle and exact hold length.
    task automatic test_stretch();
        crs = 1; step();
        chk_on("R4 activity on", 4'b0001);
        crs = 0;
        repeat (HD) step();
        chk_on("R5 still held at end of hold", 4'b0001);
        step();
        chk_on("R5 released one edge after hold", 4'b0000);
    endtask

    // R6: retrigger restarts the full hold.
    task automatic test_retrigger();
        crs = 1; step();
        crs = 0;
        repeat (HD - 2) step();
        crs = 1; step();
        chk_on("R6 on at retrigger", 4'b0001);
        crs = 0;
        for (int i = 0; i < HD; i++) begin
            step();
            chk_on("R6 held through restarted hold", 4'b0001);
        end
        step();
        chk_on("R6 released after restarted hold", 4'b0000);
    endtask

    // R2: straps changed after release have no effect.
    task automatic test_strap_ignored();
        strap = 4'b1001; step();
        chk_on("R2 idle level unchanged", 4'b0000);
        fdx = 1; strap = 4'b0110; step();
        chk_on("R2 active level unchanged", 4'b1000);
        clear_inputs(); step();
    endtask

    initial begin
        do_reset(4'b1111, 4'b0101);
        test_link();
        test_speed();
        test_duplex();
        test_stretch();
        test_retrigger();
        test_strap_ignored();
        do_reset(4'b0000, 4'b1010);
        test_link();
        test_stretch();
        test_strap_ignored();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #4_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule